// File: doc/BRIEF.md
# Age-Counter Victim Selector

This block keeps recency information for a set-associative cache and names the way to evict from any set. Every way of every set owns a small age counter. When the cache reports a hit or a fill on a way, that way becomes the youngest. Its counter jumps to the top value, and the other ways of the same set each age by one step. A way whose counter has reached zero is the least recently used and is offered as the victim.

The cache controller presents a hit or fill with a strobe, the set and the way. Independently, it puts any set on the query input and reads the victim way back in the same cycle. Tag lookup, data storage and miss sequencing are handled elsewhere. After reset, every set holds a fixed order in which way 0 is the oldest.

Top module: `lru_ages`

## Requirements
- R1: After reset, way i of every set holds age i, so the victim reported for every set is way 0.
- R2: On a clock edge with `acc_valid` high, the age of way `acc_way` in set `acc_set` becomes WAYS-1 (3 by default), which makes it the last candidate for eviction.
- R3: On that same edge, every other way of that set whose age is above zero drops by exactly one.
- R4: An age already at zero stays at zero when another way of its set is touched. It never wraps to the top value.
- R5: `victim_way` names a way of set `qry_set` whose age is zero.
- R6: When several ways of the queried set are at zero, `victim_way` is the lowest-numbered of them.
- R7: `victim_way` is a combinational function of `qry_set` and the stored ages. An access and a query to the same set in one cycle return the victim that the ages held before that access.
- R8: Sets other than `acc_set` keep their ages on an access. No age changes in a cycle where `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | A hit or fill happened this cycle |
| acc_set | input | $clog2(SETS) | Set of the hit or fill |
| acc_way | input | $clog2(WAYS) | Way that was hit or filled |
| qry_set | input | $clog2(SETS) | Set whose victim is requested |
| victim_way | output | $clog2(WAYS) | Way to evict from `qry_set` |

## Verification
The victim answer takes zero cycles. The bench drives each input on the falling edge, waits a settling delay, and compares `victim_way` against its model before the next rising edge. An access takes effect one edge later. The bench therefore updates its age model only after the rising edge that follows the strobe, so a same-cycle query is still checked against the old ages. Directed sequences drive one set through tied zeros, saturated ages and a full reordering, while other sets stay untouched. Seeded random traffic then checks every cycle against the model.

// File: rtl/lru_ages.sv
module lru_ages #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic [SW-1:0] acc_set,
  input  logic [AW-1:0] acc_way,
  input  logic [SW-1:0] qry_set,
  output logic [AW-1:0] victim_way
);

  localparam logic [AW-1:0] TOP = AW'(WAYS - 1);

  logic [SETS-1:0][WAYS-1:0][AW-1:0] age;
  logic [WAYS-1:0][AW-1:0] row;

  assign row = age[qry_set];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age[s][w] <= AW'(w);
    end else if (acc_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        if (AW'(w) == acc_way)
          age[acc_set][w] <= TOP;
        else if (age[acc_set][w] != '0)
          age[acc_set][w] <= age[acc_set][w] - 1'b1;
      end
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (row[w] == '0) victim_way = AW'(w);
  end

endmodule

// File: rtl/lru_ages_chk.sv
module lru_ages_chk #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              acc_valid,
  input logic [SW-1:0]                     acc_set,
  input logic [AW-1:0]                     acc_way,
  input logic [SW-1:0]                     qry_set,
  input logic [AW-1:0]                     victim_way,
  input logic [SETS-1:0][WAYS-1:0][AW-1:0] age
);

  logic                    p_v;
  logic [SW-1:0]           p_set;
  logic [AW-1:0]           p_way;
  logic [WAYS-1:0][AW-1:0] p_row;
  logic                    any_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_v   <= 1'b0;
      p_set <= '0;
      p_way <= '0;
      p_row <= '0;
    end else begin
      p_v   <= acc_valid;
      p_set <= acc_set;
      p_way <= acc_way;
      p_row <= age[acc_set];
    end
  end

  always_comb begin
    any_zero = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (age[qry_set][w] == '0) any_zero = 1'b1;
  end

  a_r2_load_top: assert property (@(posedge clk) disable iff (!rst_n)
    p_v |-> age[p_set][p_way] == AW'(WAYS - 1));

  a_r5_victim_zero: assert property (@(posedge clk) disable iff (!rst_n)
    any_zero |-> age[qry_set][victim_way] == '0);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (p_v && p_way != AW'(w) && p_row[w] != '0) |-> age[p_set][w] == p_row[w] - 1'b1);

    a_r4_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (p_v && p_way != AW'(w) && p_row[w] == '0) |-> age[p_set][w] == '0);

    a_r6_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (victim_way > AW'(w)) |-> age[qry_set][w] != '0);
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    a_r8_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_valid || acc_set != SW'(s)) |=> $stable(age[s]));
  end

endmodule

bind lru_ages lru_ages_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (.*);

// File: tb/sim_lru_ages.sv
module sim_lru_ages;
  localparam int WAYS = 4;
  localparam int SETS = 8;
  localparam int AW = $clog2(WAYS);
  localparam int SW = $clog2(SETS);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [SW-1:0] acc_set = '0;
  logic [AW-1:0] acc_way = '0;
  logic [SW-1:0] qry_set = '0;
  logic [AW-1:0] victim_way;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m [SETS][WAYS];

  always #5 clk = ~clk;

  lru_ages #(.WAYS(WAYS), .SETS(SETS)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .qry_set(qry_set), .victim_way(victim_way)
  );

  function automatic int mvict(int s);
    for (int w = 0; w < WAYS; w++)
      if (m[s][w] == 0) return w;
    return 0;
  endfunction

  function automatic void mtouch(int s, int w);
    for (int k = 0; k < WAYS; k++)
      if (k == w) m[s][k] = WAYS - 1;
      else if (m[s][k] > 0) m[s][k] = m[s][k] - 1;
  endfunction

  task automatic check(int act, int exp, string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: victim=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int s, int w, int q, string tag);
    @(negedge clk);
    acc_valid = v;
    acc_set = SW'(s);
    acc_way = AW'(w);
    qry_set = SW'(q);
    #1;
    check(int'(victim_way), mvict(q), tag);
    @(posedge clk);
    if (v) mtouch(s, w);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) m[s][w] = w;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int s = 0; s < SETS; s++) step(0, 0, 0, s, "R1 reset order");

    step(1, 5, 3, 5, "R7 same-cycle pre-update");
    step(0, 5, 0, 5, "R6 tie after first touch");
    step(1, 5, 0, 6, "R8 other set");
    step(0, 6, 0, 5, "R6 lowest of tied zeros");
    for (int i = 0; i < 4; i++) step(1, 5, 2, 5, "R4 repeated touch");
    step(1, 5, 0, 5, "R4 saturated ages");
    step(1, 5, 1, 5, "R4 after reorder");
    step(1, 5, 3, 5, "R3 step down");
    step(1, 5, 2, 5, "R2 top value");
    step(0, 5, 0, 5, "R2 touched way not victim");
    step(0, 6, 1, 6, "R8 idle strobe");
    step(0, 5, 0, 6, "R8 set untouched");

    for (int i = 0; i < 3000; i++) begin
      int s;
      s = int'($urandom_range(SETS - 1));
      if (($urandom & 3) == 0)
        step(1, s, int'($urandom_range(WAYS - 1)), s, "R7 random same set");
      else
        step(($urandom & 1) == 1, s, int'($urandom_range(WAYS - 1)),
             int'($urandom_range(SETS - 1)), "R5/R6 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule